// File: doc/BRIEF.md
# Strong Luma Edge Filter Datapath

This block computes the strong edge-smoothing filter applied across a luma block boundary in a video deblocking stage. Four independent 8-bit lanes are processed side by side: each lane sees four pixels on either side of the edge (p3..p0 on one side, q0..q3 on the other), its own alpha threshold, an enable flag and one smoothness flag per side. The smoothness flags come from comparisons done upstream. For each lane the block returns the three new pixels nearest the edge on each side.

Each side of the edge decides on its own how far the smoothing reaches. A side whose flag is set and whose step across the edge is small compared with alpha rewrites three pixels with wide averaging taps. Any other side rewrites only its nearest pixel with a short three-tap average and passes its other two pixels through. A lane whose enable flag is clear passes all six pixels through unchanged. The results are registered once, so they appear one clock after the inputs.

Pixels travel as 32-bit words, one word per pixel position, with lane n in bits [8n+7:8n]. Flags travel as 4-bit vectors, with lane n in bit n.

Top module: `luma_strong_filter`

## Requirements
- R1: A side is in wide mode only when its smoothness flag (`p_smooth` bit n or `q_smooth` bit n) is 1 and |p0-q0| < (alpha>>2) + 2. At equality the side is not in wide mode.
- R2: In wide mode the p side gives P0 = (p2 + 2p1 + 2p0 + 2q0 + q1 + 4)>>3, P1 = (p2 + p1 + p0 + q0 + 2)>>2 and P2 = (2p3 + 3p2 + p1 + p0 + q0 + 4)>>3, with no overflow before the shift.
- R3: In wide mode the q side gives Q0 = (q2 + 2q1 + 2q0 + 2p0 + p1 + 4)>>3, Q1 = (q2 + q1 + q0 + p0 + 2)>>2 and Q2 = (2q3 + 3q2 + q1 + q0 + p0 + 4)>>3.
- R4: An enabled side that is not in wide mode outputs (2p1 + p0 + q1 + 2)>>2 as P0, or (2q1 + q0 + p1 + 2)>>2 as Q0. Its other two outputs equal the inputs p1, p2 (or q1, q2).
- R5: When `filt_en` bit n is 0, all six outputs of lane n equal p0, p1, p2, q0, q1 and q2 of that lane.
- R6: Lanes are independent. Lane n uses only bits [8n+7:8n] of each pixel word and of `alpha`, and only bit n of each flag vector.
- R7: Outputs are registered. Inputs present before a rising clock edge give their results after that edge, and the outputs do not change between edges.
- R8: A synchronous active-low reset (`rst_n` = 0 at a rising edge) sets all six output words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p3 | input | 32 | p-side pixel furthest from the edge, four lanes |
| p2 | input | 32 | p-side pixel three from the edge |
| p1 | input | 32 | p-side pixel two from the edge |
| p0 | input | 32 | p-side pixel next to the edge |
| q0 | input | 32 | q-side pixel next to the edge |
| q1 | input | 32 | q-side pixel two from the edge |
| q2 | input | 32 | q-side pixel three from the edge |
| q3 | input | 32 | q-side pixel furthest from the edge |
| alpha | input | 32 | Per-lane edge threshold |
| filt_en | input | 4 | Per-lane filter enable |
| p_smooth | input | 4 | Per-lane p-side smoothness flag |
| q_smooth | input | 4 | Per-lane q-side smoothness flag |
| op0 | output | 32 | Filtered P0 |
| op1 | output | 32 | Filtered P1 |
| op2 | output | 32 | Filtered P2 |
| oq0 | output | 32 | Filtered Q0 |
| oq1 | output | 32 | Filtered Q1 |
| oq2 | output | 32 | Filtered Q2 |

## Verification
Every result is due exactly one rising edge after its inputs. The bench drives a new set of inputs on a falling edge and compares all lanes on the next falling edge, half a period after the register has loaded. One directed case also samples shortly after a new drive to confirm that the outputs still hold the previous results until the edge. The reset result follows the same one-edge rule, and the checker's properties compare outputs with inputs taken one cycle earlier.

// File: rtl/lsf_pkg.sv
// Package: shared definitions for the strong luma edge filter.
// Assumes: pixel sums need three guard bits above the pixel width.
package lsf_pkg;

    // Per-side filtering decision
    typedef enum logic [1:0] {
        SIDE_BYPASS = 2'd0,
        SIDE_WEAK   = 2'd1,
        SIDE_STRONG = 2'd2
    } side_mode_e;

    // Guard bits so that an 8-tap weighted sum cannot overflow
    localparam int SUM_GUARD = 3;

endpackage

// File: rtl/lsf_gate.sv
// Module: lsf_gate
// Decides whether the step across the edge is small enough for wide
// smoothing: |near_p - near_q| < (alpha >> 2) + 2.
// Assumes: unsigned pixels and alpha of PIX_W bits; purely combinational.
module lsf_gate #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] near_p,
    input  logic [PIX_W-1:0] near_q,
    input  logic [PIX_W-1:0] alpha,
    output logic             close
);

    localparam int CMP_W = PIX_W + 1;

    logic [PIX_W-1:0] step;
    logic [CMP_W-1:0] limit;

    // Absolute difference of the two pixels next to the edge
    always_comb begin
        if (near_p > near_q) step = near_p - near_q;
        else                 step = near_q - near_p;
    end

    // Limit has one extra bit so that +2 cannot wrap
    always_comb limit = {1'b0, (alpha >> 2)} + CMP_W'(2);

    // Strict comparison: equality is not close
    always_comb close = ({1'b0, step} < limit);

endmodule

// File: rtl/lsf_side.sv
// Module: lsf_side
// Filters one side of the edge for one lane. n0..n3 are the pixels of
// this side (n0 nearest the edge); o0, o1 are the two nearest pixels of
// the opposite side. The same equations serve both sides by mirroring.
// Assumes: close comes from lsf_gate; purely combinational.
module lsf_side
    import lsf_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] n0,
    input  logic [PIX_W-1:0] n1,
    input  logic [PIX_W-1:0] n2,
    input  logic [PIX_W-1:0] n3,
    input  logic [PIX_W-1:0] o0,
    input  logic [PIX_W-1:0] o1,
    input  logic             en,
    input  logic             smooth,
    input  logic             close,
    output logic [PIX_W-1:0] r0,
    output logic [PIX_W-1:0] r1,
    output logic [PIX_W-1:0] r2
);

    localparam int SUM_W = PIX_W + SUM_GUARD;

    side_mode_e       mode;
    logic [SUM_W-1:0] x0, x1, x2, x3, y0, y1;
    logic [SUM_W-1:0] s_near, s_mid, s_far, s_weak;

    // Zero-extend all taps to the sum width
    always_comb begin
        x0 = SUM_W'(n0);
        x1 = SUM_W'(n1);
        x2 = SUM_W'(n2);
        x3 = SUM_W'(n3);
        y0 = SUM_W'(o0);
        y1 = SUM_W'(o1);
    end

    // Pick the mode for this side
    always_comb begin
        if (!en)                  mode = SIDE_BYPASS;
        else if (smooth && close) mode = SIDE_STRONG;
        else                      mode = SIDE_WEAK;
    end

    // Weighted sums with rounding constants, before the shift
    always_comb begin
        s_near = x2 + (x1 << 1) + (x0 << 1) + (y0 << 1) + y1 + SUM_W'(4);
        s_mid  = x2 + x1 + x0 + y0 + SUM_W'(2);
        s_far  = (x3 << 1) + x2 + (x2 << 1) + x1 + x0 + y0 + SUM_W'(4);
        s_weak = (x1 << 1) + x0 + y1 + SUM_W'(2);
    end

    // Select the outputs of this side according to its mode
    always_comb begin
        unique case (mode)
            SIDE_STRONG: begin
                r0 = PIX_W'(s_near >> 3);
                r1 = PIX_W'(s_mid >> 2);
                r2 = PIX_W'(s_far >> 3);
            end
            SIDE_WEAK: begin
                r0 = PIX_W'(s_weak >> 2);
                r1 = n1;
                r2 = n2;
            end
            default: begin
                r0 = n0;
                r1 = n1;
                r2 = n2;
            end
        endcase
    end

endmodule

// File: rtl/lsf_lane.sv
// Module: lsf_lane
// One lane: evaluates the step test once and runs a mirrored copy of
// lsf_side for each side of the edge.
// Assumes: combinational; the top module registers the results.
module lsf_lane #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] p3,
    input  logic [PIX_W-1:0] p2,
    input  logic [PIX_W-1:0] p1,
    input  logic [PIX_W-1:0] p0,
    input  logic [PIX_W-1:0] q0,
    input  logic [PIX_W-1:0] q1,
    input  logic [PIX_W-1:0] q2,
    input  logic [PIX_W-1:0] q3,
    input  logic [PIX_W-1:0] alpha,
    input  logic             en,
    input  logic             p_smooth,
    input  logic             q_smooth,
    output logic [PIX_W-1:0] rp0,
    output logic [PIX_W-1:0] rp1,
    output logic [PIX_W-1:0] rp2,
    output logic [PIX_W-1:0] rq0,
    output logic [PIX_W-1:0] rq1,
    output logic [PIX_W-1:0] rq2
);

    localparam int SIDES = 2;
    localparam int OWN_N = 4;
    localparam int OPP_N = 2;
    localparam int RES_N = 3;

    logic             close;
    logic [PIX_W-1:0] own [SIDES][OWN_N];
    logic [PIX_W-1:0] opp [SIDES][OPP_N];
    logic [PIX_W-1:0] res [SIDES][RES_N];
    logic             smth [SIDES];

    lsf_gate #(.PIX_W(PIX_W)) u_gate (
        .near_p (p0),
        .near_q (q0),
        .alpha  (alpha),
        .close  (close)
    );

    // Arrange the taps so that side 0 sees p and side 1 sees q as its own
    always_comb begin
        own[0][0] = p0; own[0][1] = p1; own[0][2] = p2; own[0][3] = p3;
        own[1][0] = q0; own[1][1] = q1; own[1][2] = q2; own[1][3] = q3;
        opp[0][0] = q0; opp[0][1] = q1;
        opp[1][0] = p0; opp[1][1] = p1;
        smth[0]   = p_smooth;
        smth[1]   = q_smooth;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        lsf_side #(.PIX_W(PIX_W)) u_side (
            .n0     (own[s][0]),
            .n1     (own[s][1]),
            .n2     (own[s][2]),
            .n3     (own[s][3]),
            .o0     (opp[s][0]),
            .o1     (opp[s][1]),
            .en     (en),
            .smooth (smth[s]),
            .close  (close),
            .r0     (res[s][0]),
            .r1     (res[s][1]),
            .r2     (res[s][2])
        );
    end

    // Route the side results to the named outputs
    always_comb begin
        rp0 = res[0][0]; rp1 = res[0][1]; rp2 = res[0][2];
        rq0 = res[1][0]; rq1 = res[1][1]; rq2 = res[1][2];
    end

endmodule

// File: rtl/luma_strong_filter.sv
// Module: luma_strong_filter (top)
// Strong luma edge filter across LANES independent lanes, one register
// stage on the outputs. Lane n occupies bits [n*PIX_W +: PIX_W].
// Assumes: the smoothness flags are computed upstream; synchronous
// active-low reset clears the outputs.
module luma_strong_filter #(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*PIX_W-1:0] p3,
    input  logic [LANES*PIX_W-1:0] p2,
    input  logic [LANES*PIX_W-1:0] p1,
    input  logic [LANES*PIX_W-1:0] p0,
    input  logic [LANES*PIX_W-1:0] q0,
    input  logic [LANES*PIX_W-1:0] q1,
    input  logic [LANES*PIX_W-1:0] q2,
    input  logic [LANES*PIX_W-1:0] q3,
    input  logic [LANES*PIX_W-1:0] alpha,
    input  logic [LANES-1:0]       filt_en,
    input  logic [LANES-1:0]       p_smooth,
    input  logic [LANES-1:0]       q_smooth,
    output logic [LANES*PIX_W-1:0] op0,
    output logic [LANES*PIX_W-1:0] op1,
    output logic [LANES*PIX_W-1:0] op2,
    output logic [LANES*PIX_W-1:0] oq0,
    output logic [LANES*PIX_W-1:0] oq1,
    output logic [LANES*PIX_W-1:0] oq2
);

    localparam int WORD_W = LANES * PIX_W;

    logic [WORD_W-1:0] nx_p0, nx_p1, nx_p2, nx_q0, nx_q1, nx_q2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsf_lane #(.PIX_W(PIX_W)) u_lane (
            .p3       (p3[g*PIX_W +: PIX_W]),
            .p2       (p2[g*PIX_W +: PIX_W]),
            .p1       (p1[g*PIX_W +: PIX_W]),
            .p0       (p0[g*PIX_W +: PIX_W]),
            .q0       (q0[g*PIX_W +: PIX_W]),
            .q1       (q1[g*PIX_W +: PIX_W]),
            .q2       (q2[g*PIX_W +: PIX_W]),
            .q3       (q3[g*PIX_W +: PIX_W]),
            .alpha    (alpha[g*PIX_W +: PIX_W]),
            .en       (filt_en[g]),
            .p_smooth (p_smooth[g]),
            .q_smooth (q_smooth[g]),
            .rp0      (nx_p0[g*PIX_W +: PIX_W]),
            .rp1      (nx_p1[g*PIX_W +: PIX_W]),
            .rp2      (nx_p2[g*PIX_W +: PIX_W]),
            .rq0      (nx_q0[g*PIX_W +: PIX_W]),
            .rq1      (nx_q1[g*PIX_W +: PIX_W]),
            .rq2      (nx_q2[g*PIX_W +: PIX_W])
        );
    end

    // Output register stage with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op0 <= '0; op1 <= '0; op2 <= '0;
            oq0 <= '0; oq1 <= '0; oq2 <= '0;
        end else begin
            op0 <= nx_p0; op1 <= nx_p1; op2 <= nx_p2;
            oq0 <= nx_q0; oq1 <= nx_q1; oq2 <= nx_q2;
        end
    end

endmodule

// File: rtl/lsf_checker.sv
// Module: lsf_checker
// Property checker bound to luma_strong_filter. It relates each lane's
// registered outputs to the inputs seen one cycle earlier.
// Assumes: reset is held low from time zero for at least one edge.
module lsf_checker #(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES*PIX_W-1:0] p2,
    input logic [LANES*PIX_W-1:0] p1,
    input logic [LANES*PIX_W-1:0] p0,
    input logic [LANES*PIX_W-1:0] q0,
    input logic [LANES*PIX_W-1:0] q1,
    input logic [LANES*PIX_W-1:0] q2,
    input logic [LANES-1:0]       filt_en,
    input logic [LANES-1:0]       p_smooth,
    input logic [LANES-1:0]       q_smooth,
    input logic [LANES*PIX_W-1:0] op0,
    input logic [LANES*PIX_W-1:0] op1,
    input logic [LANES*PIX_W-1:0] op2,
    input logic [LANES*PIX_W-1:0] oq0,
    input logic [LANES*PIX_W-1:0] oq1,
    input logic [LANES*PIX_W-1:0] oq2
);

    // R8
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (op0 == '0 && op1 == '0 && op2 == '0 &&
                           oq0 == '0 && oq1 == '0 && oq2 == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R5
        bypass_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(filt_en[g])) |->
                (op0[g*PIX_W +: PIX_W] == $past(p0[g*PIX_W +: PIX_W]) &&
                 op1[g*PIX_W +: PIX_W] == $past(p1[g*PIX_W +: PIX_W]) &&
                 op2[g*PIX_W +: PIX_W] == $past(p2[g*PIX_W +: PIX_W]) &&
                 oq0[g*PIX_W +: PIX_W] == $past(q0[g*PIX_W +: PIX_W]) &&
                 oq1[g*PIX_W +: PIX_W] == $past(q1[g*PIX_W +: PIX_W]) &&
                 oq2[g*PIX_W +: PIX_W] == $past(q2[g*PIX_W +: PIX_W])));

        // R4
        p_outer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(filt_en[g]) && !$past(p_smooth[g])) |->
                (op1[g*PIX_W +: PIX_W] == $past(p1[g*PIX_W +: PIX_W]) &&
                 op2[g*PIX_W +: PIX_W] == $past(p2[g*PIX_W +: PIX_W])));

        // R4
        q_outer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(filt_en[g]) && !$past(q_smooth[g])) |->
                (oq1[g*PIX_W +: PIX_W] == $past(q1[g*PIX_W +: PIX_W]) &&
                 oq2[g*PIX_W +: PIX_W] == $past(q2[g*PIX_W +: PIX_W])));
    end

endmodule

bind luma_strong_filter lsf_checker #(.LANES(LANES), .PIX_W(PIX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .p2       (p2),
    .p1       (p1),
    .p0       (p0),
    .q0       (q0),
    .q1       (q1),
    .q2       (q2),
    .filt_en  (filt_en),
    .p_smooth (p_smooth),
    .q_smooth (q_smooth),
    .op0      (op0),
    .op1      (op1),
    .op2      (op2),
    .oq0      (oq0),
    .oq1      (oq1),
    .oq2      (oq2)
);

// File: tb/luma_strong_filter_tb.sv
`timescale 1ns/1ps
module luma_strong_filter_tb;

    localparam int LANES = 4;
    localparam int W     = 32;
    localparam int NVEC  = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] p3, p2, p1, p0, q0, q1, q2, q3, alpha;
    logic [LANES-1:0] filt_en, p_smooth, q_smooth;
    logic [W-1:0] op0, op1, op2, oq0, oq1, oq2;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    luma_strong_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .p3(p3), .p2(p2), .p1(p1), .p0(p0),
        .q0(q0), .q1(q1), .q2(q2), .q3(q3),
        .alpha(alpha), .filt_en(filt_en),
        .p_smooth(p_smooth), .q_smooth(q_smooth),
        .op0(op0), .op1(op1), .op2(op2),
        .oq0(oq0), .oq1(oq1), .oq2(oq2)
    );

    typedef struct packed {
        logic [7:0] vp3, vp2, vp1, vp0, vq0, vq1, vq2, vq3, va;
        logic       ven, vps, vqs;
        logic [7:0] ep0, ep1, ep2, eq0, eq1, eq2;
    } vec_t;

    // Stimulus and expected results, worked out by hand from the equations
    localparam vec_t TBL [NVEC] = '{
        // R2 R3: flat area stays flat
        '{8'd100,8'd100,8'd100,8'd100,8'd100,8'd100,8'd100,8'd100, 8'd40,
          1'b1,1'b1,1'b1, 8'd100,8'd100,8'd100,8'd100,8'd100,8'd100},
        // R2 R3: step of 20, limit 27
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd100,
          1'b1,1'b1,1'b1, 8'd68,8'd65,8'd63,8'd73,8'd75,8'd78},
        // R1 R4: step 20 equals limit 20, both sides short
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd72,
          1'b1,1'b1,1'b1, 8'd65,8'd60,8'd60,8'd75,8'd80,8'd80},
        // R1: limit 21, just wide
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd76,
          1'b1,1'b1,1'b1, 8'd68,8'd65,8'd63,8'd73,8'd75,8'd78},
        // R1: p side wide, q flag clear
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd100,
          1'b1,1'b1,1'b0, 8'd68,8'd65,8'd63,8'd75,8'd80,8'd80},
        // R5: lane disabled
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd100,
          1'b0,1'b1,1'b1, 8'd60,8'd60,8'd60,8'd80,8'd80,8'd80},
        // R2 R3: top of range, no overflow
        '{8'd255,8'd255,8'd255,8'd255,8'd250,8'd250,8'd250,8'd250, 8'd255,
          1'b1,1'b1,1'b1, 8'd253,8'd254,8'd254,8'd252,8'd251,8'd251},
        // R4: ramp, alpha 0 gives limit 2
        '{8'd10,8'd20,8'd30,8'd40,8'd50,8'd60,8'd70,8'd80, 8'd0,
          1'b1,1'b1,1'b1, 8'd40,8'd30,8'd20,8'd50,8'd60,8'd70},
        // R2 R3: ramp, limit 12
        '{8'd10,8'd20,8'd30,8'd40,8'd50,8'd60,8'd70,8'd80, 8'd40,
          1'b1,1'b1,1'b1, 8'd40,8'd35,8'd25,8'd50,8'd55,8'd65},
        // R1: both flags clear, close step
        '{8'd60,8'd60,8'd60,8'd60,8'd80,8'd80,8'd80,8'd80, 8'd100,
          1'b1,1'b0,1'b0, 8'd65,8'd60,8'd60,8'd75,8'd80,8'd80}
    };

    // Independent per-lane model, written from the requirement text
    function automatic logic [47:0] model(input int a3, a2, a1, a0,
                                          input int b0, b1, b2, b3,
                                          input int al, input bit en,
                                          input bit ps, input bit qs);
        int d, lim, r [6];
        bit wp, wq;
        d   = (a0 > b0) ? a0 - b0 : b0 - a0;
        lim = al / 4 + 2;
        wp  = ps && (d < lim);
        wq  = qs && (d < lim);
        r[0] = a0; r[1] = a1; r[2] = a2; r[3] = b0; r[4] = b1; r[5] = b2;
        if (en) begin
            if (wp) begin
                r[0] = (a2 + 2*a1 + 2*a0 + 2*b0 + b1 + 4) / 8;
                r[1] = (a2 + a1 + a0 + b0 + 2) / 4;
                r[2] = (2*a3 + 3*a2 + a1 + a0 + b0 + 4) / 8;
            end else begin
                r[0] = (2*a1 + a0 + b1 + 2) / 4;
            end
            if (wq) begin
                r[3] = (b2 + 2*b1 + 2*b0 + 2*a0 + a1 + 4) / 8;
                r[4] = (b2 + b1 + b0 + a0 + 2) / 4;
                r[5] = (2*b3 + 3*b2 + b1 + b0 + a0 + 4) / 8;
            end else begin
                r[3] = (2*b1 + b0 + a1 + 2) / 4;
            end
        end
        return {r[0][7:0], r[1][7:0], r[2][7:0], r[3][7:0], r[4][7:0], r[5][7:0]};
    endfunction

    function automatic logic [47:0] lane_out(input int l);
        return {op0[l*8 +: 8], op1[l*8 +: 8], op2[l*8 +: 8],
                oq0[l*8 +: 8], oq1[l*8 +: 8], oq2[l*8 +: 8]};
    endfunction

    task automatic check(input string tag, input int l, input logic [47:0] exp_v);
        logic [47:0] act;
        act = lane_out(l);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual %h expected %h", tag, l, act, exp_v);
        end
    endtask

    task automatic put_vec(input int l, input vec_t v);
        p3[l*8 +: 8] = v.vp3; p2[l*8 +: 8] = v.vp2;
        p1[l*8 +: 8] = v.vp1; p0[l*8 +: 8] = v.vp0;
        q0[l*8 +: 8] = v.vq0; q1[l*8 +: 8] = v.vq1;
        q2[l*8 +: 8] = v.vq2; q3[l*8 +: 8] = v.vq3;
        alpha[l*8 +: 8] = v.va;
        filt_en[l] = v.ven; p_smooth[l] = v.vps; q_smooth[l] = v.vqs;
    endtask

    function automatic logic [47:0] exp_of(input vec_t v);
        return {v.ep0, v.ep1, v.ep2, v.eq0, v.eq1, v.eq2};
    endfunction

    // Watchdog: a hung run is one failed check and still reports
    initial begin
        #80000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [47:0] ex [LANES];
        rst_n = 1'b0;
        for (int l = 0; l < LANES; l++) put_vec(l, TBL[1]);
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held
        for (int l = 0; l < LANES; l++) check("R8 reset", l, 48'd0);
        rst_n = 1'b1;

        // Table walk: each vector in all lanes
        for (int k = 0; k < NVEC; k++) begin
            for (int l = 0; l < LANES; l++) put_vec(l, TBL[k]);
            @(negedge clk);
            for (int l = 0; l < LANES; l++)
                check($sformatf("R1-table %0d", k), l, exp_of(TBL[k]));
        end

        // R7: a new drive does not show before the next rising edge
        for (int l = 0; l < LANES; l++) put_vec(l, TBL[1]);
        #1;
        for (int l = 0; l < LANES; l++) check("R7 hold", l, exp_of(TBL[NVEC-1]));
        @(negedge clk);
        for (int l = 0; l < LANES; l++) check("R7 update", l, exp_of(TBL[1]));

        // R6: different vectors per lane
        for (int l = 0; l < LANES; l++) put_vec(l, TBL[(l * 3 + 2) % NVEC]);
        @(negedge clk);
        for (int l = 0; l < LANES; l++)
            check("R6 lanes", l, exp_of(TBL[(l * 3 + 2) % NVEC]));

        // Random and boundary patterns against the model, all flag mixes
        for (int it = 0; it < 600; it++) begin
            for (int l = 0; l < LANES; l++) begin
                int v [8];
                int al, lim;
                for (int j = 0; j < 8; j++) v[j] = $urandom_range(255);
                al  = $urandom_range(255);
                lim = al / 4 + 2;
                if (it % 3 == 0) begin
                    // step at the limit or one below
                    v[3] = $urandom_range(255 - lim);
                    v[4] = v[3] + lim - (it % 2);
                end
                p3[l*8 +: 8] = 8'(v[0]); p2[l*8 +: 8] = 8'(v[1]);
                p1[l*8 +: 8] = 8'(v[2]); p0[l*8 +: 8] = 8'(v[3]);
                q0[l*8 +: 8] = 8'(v[4]); q1[l*8 +: 8] = 8'(v[5]);
                q2[l*8 +: 8] = 8'(v[6]); q3[l*8 +: 8] = 8'(v[7]);
                alpha[l*8 +: 8] = 8'(al);
                filt_en[l]  = ((it + l) % 8) != 7;
                p_smooth[l] = (((it + l) >> 1) % 2) == 1;
                q_smooth[l] = (((it + l) >> 2) % 2) == 1;
                ex[l] = model(v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7],
                              al, filt_en[l], p_smooth[l], q_smooth[l]);
            end
            @(negedge clk);
            for (int l = 0; l < LANES; l++) check("R2/R3/R4/R5 random", l, ex[l]);
        end

        // R8: reset in mid run clears the outputs at the next edge
        for (int l = 0; l < LANES; l++) put_vec(l, TBL[6]);
        rst_n = 1'b0;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) check("R8 mid reset", l, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) check("R2 after reset", l, exp_of(TBL[6]));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule